// File: doc/BRIEF.md
# Per-Set Round-Robin Victim Selector

This block picks which way of a set-associative data cache receives the next line fill. Each set owns a replacement pointer. Requesting a set returns that set's victim way straight away, with no clock in the path. When a fill completes, the fill strobe and its set index move that set's pointer to the way after the one just filled. All other pointers keep their values.

Software can reserve a contiguous block of low-numbered ways in a set as local RAM. A per-set lock count describes these ways, and they are never offered for replacement. When a pointer passes the top way, it wraps to the first unlocked way rather than to way 0. If a lock count grows past a set's stored pointer, the victim is clamped up to the first unlocked way. After reset, every pointer selects the highest way.

A kind parameter lets the same logic serve two caches. One is a 32-way main cache. The other is a 2-way auxiliary cache, where the scheme always names the least recently filled line.

Top module: `rr_victim_sel`

## Requirements
- R1: A fill in one set leaves the victim reported for every other set unchanged.
- R2: After a fill into way w of a set, where w is below the top way, that set's victim becomes way w+1.
- R3: While `rst_n` is low at a rising clock edge, every set's pointer is set to the top way (way 31 for the main kind, way 1 for the auxiliary kind).
- R4: A fill into the top way moves the set's victim to way L, where L is the set's lock count; for example, way 3 when ways 0 to 2 are locked (L = 3).
- R5: With a lock count of 0, a fill into way 31 of the main kind moves the victim to way 0.
- R6: The auxiliary kind has 2 ways. With no lock, successive fills into one set alternate its victim 1, 0, 1, 0 from reset, so the victim is always the least recently filled line. With lock count 1, the victim stays at way 1.
- R7: `victim_way` follows `req_set` and `lock_cnt` combinationally. A fill takes effect on the rising edge at which `fill_en` is high, and the new victim is visible right after that edge.
- R8: If a set's lock count exceeds its stored pointer, the victim for that set is the lock count. A fill then advances from that clamped way.
- R9: The victim way is never below the lock count of the requested set. The lock count of set s occupies bits [s*WAY_W +: WAY_W] of `lock_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_en | input | 1 | A line fill into the current victim of `fill_set` completes this cycle |
| fill_set | input | SET_W | Set index of the fill |
| lock_cnt | input | SETS*WAY_W | Per-set count of low ways reserved as RAM (0 to WAYS-1) |
| req_set | input | SET_W | Set whose victim is requested |
| victim_way | output | WAY_W | Way to replace in `req_set` |

## Verification
The victim is combinational: a change of `req_set` or of a lock count shows on `victim_way` within the same cycle. A fill shows one edge later, at the rising edge that samples `fill_en`. The bench changes inputs only at falling edges and samples one nanosecond after the change. It also makes one check one nanosecond after the fill edge itself, which confirms the new victim appears with no extra register stage. Expected ways come from an arithmetic model of each set's pointer, clamp and wrap. Directed sweeps through full wraps are followed by a pseudo-random mix of lock changes and fills on both cache kinds.

// File: rtl/rr_pkg.sv
// Package: shared kinds and sizes for the round-robin victim selector.
// Assumes: only two cache kinds exist, each with a fixed way count.
package rr_pkg;
    typedef enum logic [0:0] {
        RR_MAIN = 1'b0,
        RR_AUX  = 1'b1
    } rr_kind_e;

    localparam int MAIN_WAYS = 32;
    localparam int AUX_WAYS  = 2;

    // Way count implied by a cache kind.
    function automatic int ways_for(rr_kind_e kind);
        return (kind == RR_AUX) ? AUX_WAYS : MAIN_WAYS;
    endfunction
endpackage

// File: rtl/rr_clamp.sv
// rr_clamp: raises a stored pointer to the first unlocked way.
// Assumes: locked ways are the contiguous block 0 .. lock_i-1.
module rr_clamp #(
    parameter int WAY_W = 5
) (
    input  logic [WAY_W-1:0] ptr_i,
    input  logic [WAY_W-1:0] lock_i,
    output logic [WAY_W-1:0] eff_o
);
    // Pick the larger of the pointer and the lock floor.
    always_comb begin
        eff_o = (ptr_i < lock_i) ? lock_i : ptr_i;
    end
endmodule

// File: rtl/rr_advance.sv
// rr_advance: next pointer after a fill into the effective victim way.
// Assumes: eff_i is already clamped to at least lock_i.
module rr_advance #(
    parameter int WAYS  = 32,
    parameter int WAY_W = 5
) (
    input  logic [WAY_W-1:0] eff_i,
    input  logic [WAY_W-1:0] lock_i,
    output logic [WAY_W-1:0] nxt_o
);
    localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

    // Step forward, wrapping from the top way to the first unlocked way.
    always_comb begin
        if (eff_i == LAST) begin
            nxt_o = lock_i;
        end else begin
            nxt_o = eff_i + WAY_W'(1);
        end
    end
endmodule

// File: rtl/rr_ptr_bank.sv
// rr_ptr_bank: one pointer register per set, written only by a fill.
// Assumes: synchronous active-low reset; all pointers reset to the top way.
module rr_ptr_bank #(
    parameter int SETS  = 16,
    parameter int WAYS  = 32,
    parameter int SET_W = 4,
    parameter int WAY_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SET_W-1:0]      wr_set,
    input  logic [WAY_W-1:0]      wr_ptr,
    output logic [SETS*WAY_W-1:0] ptr_flat
);
    localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAY_W-1:0] ptr_q;

        // Hold or update this set's pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q <= LAST;
            end else if (wr_en && (wr_set == SET_W'(s))) begin
                ptr_q <= wr_ptr;
            end
        end

        assign ptr_flat[s*WAY_W +: WAY_W] = ptr_q;
    end
endmodule

// File: rtl/rr_victim_sel.sv
// rr_victim_sel: per-set round-robin replacement pointer with locked-way skip.
// Assumes: the fill always targets the current victim of fill_set; lock counts
// stay within 0 .. WAYS-1; SETS is at least 2.
module rr_victim_sel #(
    parameter rr_pkg::rr_kind_e KIND = rr_pkg::RR_MAIN,
    parameter int SETS = 16,
    localparam int WAYS  = rr_pkg::ways_for(KIND),
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_en,
    input  logic [SET_W-1:0]      fill_set,
    input  logic [SETS*WAY_W-1:0] lock_cnt,
    input  logic [SET_W-1:0]      req_set,
    output logic [WAY_W-1:0]      victim_way
);
    logic [SETS*WAY_W-1:0] ptr_flat;
    logic [WAY_W-1:0]      fill_ptr, fill_lock, fill_eff, fill_nxt;
    logic [WAY_W-1:0]      req_ptr, req_lock;

    // Select the filled set's pointer and lock count.
    always_comb begin
        fill_ptr  = ptr_flat[fill_set*WAY_W +: WAY_W];
        fill_lock = lock_cnt[fill_set*WAY_W +: WAY_W];
    end

    // Select the requested set's pointer and lock count.
    always_comb begin
        req_ptr  = ptr_flat[req_set*WAY_W +: WAY_W];
        req_lock = lock_cnt[req_set*WAY_W +: WAY_W];
    end

    rr_clamp #(.WAY_W(WAY_W)) u_fill_clamp (
        .ptr_i  (fill_ptr),
        .lock_i (fill_lock),
        .eff_o  (fill_eff)
    );

    rr_advance #(.WAYS(WAYS), .WAY_W(WAY_W)) u_adv (
        .eff_i  (fill_eff),
        .lock_i (fill_lock),
        .nxt_o  (fill_nxt)
    );

    rr_ptr_bank #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_en),
        .wr_set   (fill_set),
        .wr_ptr   (fill_nxt),
        .ptr_flat (ptr_flat)
    );

    rr_clamp #(.WAY_W(WAY_W)) u_req_clamp (
        .ptr_i  (req_ptr),
        .lock_i (req_lock),
        .eff_o  (victim_way)
    );
endmodule

// File: rtl/rr_victim_sel_chk.sv
// rr_victim_sel_chk: temporal checks on the victim selector's ports.
// Assumes: bound into every rr_victim_sel instance.
module rr_victim_sel_chk #(
    parameter int SETS  = 16,
    parameter int WAYS  = 32,
    parameter int WAY_W = 5,
    parameter int SET_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fill_en,
    input logic [SET_W-1:0]      fill_set,
    input logic [SETS*WAY_W-1:0] lock_cnt,
    input logic [SET_W-1:0]      req_set,
    input logic [WAY_W-1:0]      victim_way
);
    localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] req_lock;
    logic [WAY_W-1:0] exp_step;

    // Lock count of the requested set and the victim expected after one fill.
    always_comb begin
        req_lock = lock_cnt[req_set*WAY_W +: WAY_W];
        exp_step = (victim_way == LAST) ? req_lock : victim_way + WAY_W'(1);
    end

    assert_reset_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> victim_way == LAST);

    assert_lock_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        victim_way >= req_lock);

    // R7: without a fill and with steady inputs the victim holds.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> (!$stable(req_set) || !$stable(lock_cnt) || $stable(victim_way)));

    // R2, R4: a fill into the watched set steps or wraps its victim.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_set == req_set) |=>
            (!$stable(req_set) || !$stable(lock_cnt) || victim_way == $past(exp_step)));

    assert_other_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_set != req_set) |=>
            (!$stable(req_set) || !$stable(lock_cnt) || $stable(victim_way)));
endmodule

bind rr_victim_sel rr_victim_sel_chk #(
    .SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W), .SET_W(SET_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_set   (fill_set),
    .lock_cnt   (lock_cnt),
    .req_set    (req_set),
    .victim_way (victim_way)
);

// File: tb/tb_rr_victim_sel.sv
`timescale 1ns/1ps
module tb_rr_victim_sel;
    localparam int SETS = 4;
    localparam int SW   = 2;
    localparam int MW   = 32;
    localparam int MWW  = 5;
    localparam int AW   = 2;
    localparam int AWW  = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              m_fill_en = 1'b0, a_fill_en = 1'b0;
    logic [SW-1:0]     m_fill_set = '0, a_fill_set = '0;
    logic [SW-1:0]     m_req = '0, a_req = '0;
    logic [SETS*MWW-1:0] m_lock;
    logic [SETS*AWW-1:0] a_lock;
    logic [MWW-1:0]    m_victim;
    logic [AWW-1:0]    a_victim;

    int m_ptr[SETS];
    int m_lk[SETS];
    int a_ptr[SETS];
    int a_lk[SETS];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] lf = 16'hACE1;

    // Pack the bench lock counts onto the lock buses.
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            m_lock[s*MWW +: MWW] = MWW'(m_lk[s]);
            a_lock[s*AWW +: AWW] = AWW'(a_lk[s]);
        end
    end

    rr_victim_sel #(.KIND(rr_pkg::RR_MAIN), .SETS(SETS)) dut (
        .clk(clk), .rst_n(rst_n), .fill_en(m_fill_en), .fill_set(m_fill_set),
        .lock_cnt(m_lock), .req_set(m_req), .victim_way(m_victim));

    rr_victim_sel #(.KIND(rr_pkg::RR_AUX), .SETS(SETS)) dut_aux (
        .clk(clk), .rst_n(rst_n), .fill_en(a_fill_en), .fill_set(a_fill_set),
        .lock_cnt(a_lock), .req_set(a_req), .victim_way(a_victim));

    function automatic int eff(int p, int l);
        return (p < l) ? l : p;
    endfunction

    function automatic int step(int p, int l, int ways);
        int e;
        e = eff(p, l);
        return (e == ways - 1) ? l : e + 1;
    endfunction

    task automatic rnd(output int v);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        v = int'(lf);
    endtask

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_m(input int s, input string tag);
        @(negedge clk);
        m_req = SW'(s);
        #1;
        cmp(tag, int'(m_victim), eff(m_ptr[s], m_lk[s]));
    endtask

    task automatic chk_a(input int s, input string tag);
        @(negedge clk);
        a_req = SW'(s);
        #1;
        cmp(tag, int'(a_victim), eff(a_ptr[s], a_lk[s]));
    endtask

    task automatic fill_m(input int s);
        @(negedge clk);
        m_fill_en = 1'b1;
        m_fill_set = SW'(s);
        m_ptr[s] = step(m_ptr[s], m_lk[s], MW);
        @(negedge clk);
        m_fill_en = 1'b0;
    endtask

    task automatic fill_a(input int s);
        @(negedge clk);
        a_fill_en = 1'b1;
        a_fill_set = SW'(s);
        a_ptr[s] = step(a_ptr[s], a_lk[s], AW);
        @(negedge clk);
        a_fill_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, s, kind;
        for (int i = 0; i < SETS; i++) begin
            m_ptr[i] = MW - 1; m_lk[i] = 0;
            a_ptr[i] = AW - 1; a_lk[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: all sets select the top way after reset.
        for (int i = 0; i < SETS; i++) chk_m(i, "R3");
        for (int i = 0; i < SETS; i++) chk_a(i, "R3");

        // R5 and R2: set 0 without locks through a full wrap.
        fill_m(0);
        chk_m(0, "R5");
        for (int i = 0; i < MW; i++) begin
            fill_m(0);
            chk_m(0, "R2");
        end
        // R1: other sets untouched by set 0 fills.
        for (int i = 1; i < SETS; i++) chk_m(i, "R1");

        // R7: new victim visible right after the fill edge.
        @(negedge clk);
        m_req = 2'd0;
        m_fill_en = 1'b1;
        m_fill_set = 2'd0;
        m_ptr[0] = step(m_ptr[0], m_lk[0], MW);
        @(posedge clk);
        #1;
        cmp("R7", int'(m_victim), eff(m_ptr[0], m_lk[0]));
        @(negedge clk);
        m_fill_en = 1'b0;

        // R4: set 1 with ways 0..2 locked wraps to way 3.
        m_lk[1] = 3;
        fill_m(1);
        chk_m(1, "R4");
        cmp("R4", int'(m_victim), 3);
        for (int i = 0; i < MW - 3; i++) fill_m(1);
        chk_m(1, "R4");
        cmp("R4", int'(m_victim), 3);

        // R8: lock raised above the stored pointer clamps the victim.
        fill_m(2);
        chk_m(2, "R2");
        m_lk[2] = 5;
        chk_m(2, "R8");
        cmp("R8", int'(m_victim), 5);
        fill_m(2);
        chk_m(2, "R8");
        cmp("R8", int'(m_victim), 6);

        // R6: auxiliary set 0 alternates 1,0,1,0.
        chk_a(0, "R6");
        cmp("R6", int'(a_victim), 1);
        for (int i = 0; i < 6; i++) begin
            fill_a(0);
            chk_a(0, "R6");
            cmp("R6", int'(a_victim), (i % 2 == 0) ? 0 : 1);
        end
        a_lk[1] = 1;
        for (int i = 0; i < 3; i++) begin
            fill_a(1);
            chk_a(1, "R6");
            cmp("R6", int'(a_victim), 1);
        end

        // R1, R9: pseudo-random mix on both kinds.
        for (int it = 0; it < 400; it++) begin
            rnd(v);
            s = v % SETS;
            kind = (v >> 4) % 4;
            if (kind == 0) begin
                rnd(v);
                m_lk[s] = v % MW;
                a_lk[s] = (v >> 5) % AW;
            end else begin
                fill_m(s);
                fill_a(s);
            end
            for (int i = 0; i < SETS; i++) begin
                chk_m(i, "R1");
                cmp("R9", (int'(m_victim) >= m_lk[i]) ? 1 : 0, 1);
            end
            chk_a(s, "R1");
        end

        finish_run();
    end
endmodule